// File: doc/BRIEF.md
# Tag-Broadcast Issue Queue Wakeup

This block is the instruction window of a four-wide out-of-order core. It holds up to 64 instructions. Each instruction has a payload and two source operands, and each operand carries a data field, a producer tag and a valid bit. Up to four instructions enter per cycle. They are placed in the lowest-numbered free entries, which a priority search finds, so no write address is supplied. Up to four result buses broadcast a destination tag with a value. Every operand slot still waiting for its value compares its tag against each bus and takes the value when the tags match. An entry whose two operands are both valid is ready. A fixed-priority selector reads out up to four ready entries per cycle, lowest index first, and those entries become free in the following cycle.

Each slot has one comparator per bus, which gives eight per entry. A comparator only runs when its entry is allocated, its operand is still waiting and its bus is driven. The comparison is staged. Tag bits 1:0 are checked first, then bits 3:2. The upper four bits are evaluated only when the low nibble has matched. Two registered counters report, one cycle late, how many comparators reached the upper stage and how many matched fully. A testbench can use them to observe the gating.

Top module: `iq_wakeup_queue`

## Requirements
- R1: After reset, no issue port is valid, `disp_ready` is 1 and both counters read 0.
- R2: When `disp_ready` is 1, each dispatch port with `disp_valid` set writes one free entry. Ports fill entries in ascending port order, taking the lowest-numbered free entries first. An instruction dispatched with both operands ready is read out in the next cycle.
- R3: When a bus with `bus_valid` set carries a tag equal to a waiting operand's tag, its value is stored in that operand at the clock edge and the operand becomes valid. An entry that is then ready is read out in the cycle after the broadcast, carrying that value.
- R4: An entry is read out only when both of its operands are valid. Waking one of two waiting operands keeps the entry waiting.
- R5: When several buses match the same waiting operand in one cycle, the lowest-numbered bus supplies the value.
- R6: A dispatched operand marked not ready whose tag matches a valid bus in the dispatch cycle is written as valid with that bus's value. Such dispatch-time captures are not counted by the counters.
- R7: `upper_evals` gives the number of enabled comparators whose tag bits 3:0 equalled the bus tag in the previous cycle. `full_hits` gives the number whose full 8-bit tag equalled the bus tag in that cycle. A low-nibble mismatch, including a match in bits 1:0 only, never reaches the upper stage.
- R8: Comparators of free entries and of operands that are already valid do not evaluate. A valid operand is not overwritten by a later broadcast of its tag. With no bus valid, both counters read 0 in the next cycle.
- R9: Up to four ready entries are read out per cycle on issue ports 0..3 in ascending entry order, with valid ports packed from port 0. Each entry read out is free in the next cycle.
- R10: When fewer free entries exist than instructions offered, `disp_ready` is 0 and none of the offered instructions is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_valid | input | 4 | Dispatch request per port |
| disp_payload | input | 4x8 | Instruction payload per port |
| disp_src_rdy | input | 4x2 | Operand already valid, per port and operand |
| disp_src_tag | input | 4x2x8 | Producer tag per port and operand |
| disp_src_data | input | 4x2x16 | Operand value when ready |
| disp_ready | output | 1 | All offered instructions fit and are accepted this cycle |
| bus_valid | input | 4 | Result bus carries a result |
| bus_tag | input | 4x8 | Destination tag per bus |
| bus_data | input | 4x16 | Result value per bus |
| iss_valid | output | 4 | Issue port carries an instruction |
| iss_payload | output | 4x8 | Payload read out per port |
| iss_data | output | 4x2x16 | Both operand values read out per port |
| upper_evals | output | 10 | Upper-stage comparator evaluations of the previous cycle |
| full_hits | output | 10 | Full tag matches of the previous cycle |

## Verification
Tags that match only in bits 1:0, only in the low nibble, or in all eight bits are broadcast against waiting operands. Counter readings of 0/0, 1/0 and 1/1 separate a gating fault from a comparison fault. A second broadcast of an already captured tag, arriving alongside a new tag, shows whether filled slots still compare or get overwritten. Simultaneous matches on several buses expose the bus priority. A broadcast that wakes six entries at once, with all twelve slot-bus pairs sharing the low nibble, checks counting, issue packing and ordering together. Filling the queue to 62 and then to 64 entries checks the all-or-nothing stall, and a full drain confirms that no rejected instruction ever entered.

// File: rtl/iq_pkg.sv
package iq_pkg;
  localparam int TAG_BITS = 8;
  typedef logic [TAG_BITS-1:0] tag_t;

  // stage 0: bits 1:0
  function automatic logic stage0_eq(tag_t a, tag_t b);
    return a[1:0] == b[1:0];
  endfunction

  // stage 1: bits 3:2
  function automatic logic stage1_eq(tag_t a, tag_t b);
    return a[3:2] == b[3:2];
  endfunction

  // upper stage: bits 7:4
  function automatic logic upper_eq(tag_t a, tag_t b);
    return a[7:4] == b[7:4];
  endfunction

  function automatic logic tag_eq(tag_t a, tag_t b);
    return a == b;
  endfunction
endpackage

// File: rtl/iq_tag_cmp.sv
module iq_tag_cmp
  import iq_pkg::*;
(
  input  logic en,
  input  tag_t slot_tag,
  input  tag_t bus_tag,
  output logic upper_eval,
  output logic hit
);
  logic low_pair;
  logic low_nibble;

  assign low_pair   = en & stage0_eq(slot_tag, bus_tag);
  assign low_nibble = low_pair & stage1_eq(slot_tag, bus_tag);
  assign upper_eval = low_nibble;
  assign hit        = low_nibble & upper_eq(slot_tag, bus_tag);
endmodule

// File: rtl/iq_prio_pick.sv
module iq_prio_pick #(
  parameter int N = 64,
  parameter int P = 4,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]         req,
  output logic [P-1:0]         ok,
  output logic [P-1:0][IW-1:0] idx
);
  always_comb begin
    logic [N-1:0] left;
    left = req;
    for (int p = 0; p < P; p++) begin
      ok[p]  = 1'b0;
      idx[p] = '0;
      for (int i = N - 1; i >= 0; i--) begin
        if (left[i]) begin
          ok[p]  = 1'b1;
          idx[p] = IW'(i);
        end
      end
      if (ok[p]) left[idx[p]] = 1'b0;
    end
  end
endmodule

// File: rtl/iq_wakeup_queue.sv
module iq_wakeup_queue
  import iq_pkg::*;
#(
  parameter int N_ENT  = 64,
  parameter int P      = 4,
  parameter int DATA_W = 16,
  parameter int PAY_W  = 8,
  localparam int CNT_W = $clog2(N_ENT * 2 * P + 1)
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [P-1:0]                        disp_valid,
  input  logic [P-1:0][PAY_W-1:0]             disp_payload,
  input  logic [P-1:0][1:0]                   disp_src_rdy,
  input  logic [P-1:0][1:0][TAG_BITS-1:0]     disp_src_tag,
  input  logic [P-1:0][1:0][DATA_W-1:0]       disp_src_data,
  output logic                                disp_ready,
  input  logic [P-1:0]                        bus_valid,
  input  logic [P-1:0][TAG_BITS-1:0]          bus_tag,
  input  logic [P-1:0][DATA_W-1:0]            bus_data,
  output logic [P-1:0]                        iss_valid,
  output logic [P-1:0][PAY_W-1:0]             iss_payload,
  output logic [P-1:0][1:0][DATA_W-1:0]       iss_data,
  output logic [CNT_W-1:0]                    upper_evals,
  output logic [CNT_W-1:0]                    full_hits
);
  localparam int IDX_W = $clog2(N_ENT);

  logic [N_ENT-1:0]                      ent_v;
  logic [N_ENT-1:0][1:0]                 op_v;
  logic [N_ENT-1:0][1:0][TAG_BITS-1:0]   op_tag;
  logic [N_ENT-1:0][1:0][DATA_W-1:0]     op_data;
  logic [N_ENT-1:0][PAY_W-1:0]           ent_pay;

  // comparator array: entry x operand x bus
  logic [N_ENT-1:0][1:0][P-1:0] up_ev;
  logic [N_ENT-1:0][1:0][P-1:0] hit;

  for (genvar e = 0; e < N_ENT; e++) begin : g_ent
    for (genvar s = 0; s < 2; s++) begin : g_slot
      for (genvar b = 0; b < P; b++) begin : g_bus
        iq_tag_cmp u_cmp (
          .en        (ent_v[e] & ~op_v[e][s] & bus_valid[b]),
          .slot_tag  (op_tag[e][s]),
          .bus_tag   (bus_tag[b]),
          .upper_eval(up_ev[e][s][b]),
          .hit       (hit[e][s][b])
        );
      end
    end
  end

  // wakeup: lowest-numbered matching bus supplies the value
  logic [N_ENT-1:0][1:0]             wake;
  logic [N_ENT-1:0][1:0][DATA_W-1:0] wake_data;
  always_comb begin
    for (int e = 0; e < N_ENT; e++) begin
      for (int s = 0; s < 2; s++) begin
        wake[e][s]      = |hit[e][s];
        wake_data[e][s] = '0;
        for (int b = P - 1; b >= 0; b--)
          if (hit[e][s][b]) wake_data[e][s] = bus_data[b];
      end
    end
  end

  logic [CNT_W-1:0] up_sum, hit_sum;
  always_comb begin
    up_sum  = '0;
    hit_sum = '0;
    for (int e = 0; e < N_ENT; e++)
      for (int s = 0; s < 2; s++)
        for (int b = 0; b < P; b++) begin
          up_sum  = up_sum + CNT_W'(up_ev[e][s][b]);
          hit_sum = hit_sum + CNT_W'(hit[e][s][b]);
        end
  end

  // select and free search
  logic [N_ENT-1:0] ready, free;
  always_comb begin
    for (int e = 0; e < N_ENT; e++)
      ready[e] = ent_v[e] & op_v[e][0] & op_v[e][1];
    free = ~ent_v;
  end

  logic [P-1:0][IDX_W-1:0] iss_slot;
  iq_prio_pick #(.N(N_ENT), .P(P)) u_sel (
    .req(ready), .ok(iss_valid), .idx(iss_slot)
  );

  logic [P-1:0]            free_ok;
  logic [P-1:0][IDX_W-1:0] free_idx;
  iq_prio_pick #(.N(N_ENT), .P(P)) u_free (
    .req(free), .ok(free_ok), .idx(free_idx)
  );

  always_comb begin
    for (int p = 0; p < P; p++) begin
      iss_payload[p] = ent_pay[iss_slot[p]];
      iss_data[p]    = op_data[iss_slot[p]];
    end
  end

  // dispatch: port j takes the free entry ranked by earlier active ports
  logic [P-1:0][IDX_W-1:0]       disp_slot;
  logic [P-1:0][1:0]             cap_v;
  logic [P-1:0][1:0][DATA_W-1:0] cap_d;
  always_comb begin
    int rank;
    rank       = 0;
    disp_ready = 1'b1;
    for (int j = 0; j < P; j++) begin
      disp_slot[j] = free_idx[rank];
      if (disp_valid[j]) begin
        if (!free_ok[rank]) disp_ready = 1'b0;
        rank = rank + 1;
      end
      for (int s = 0; s < 2; s++) begin
        cap_v[j][s] = disp_src_rdy[j][s];
        cap_d[j][s] = disp_src_data[j][s];
        if (!disp_src_rdy[j][s]) begin
          for (int b = P - 1; b >= 0; b--) begin
            if (bus_valid[b] && tag_eq(bus_tag[b], disp_src_tag[j][s])) begin
              cap_v[j][s] = 1'b1;
              cap_d[j][s] = bus_data[b];
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_v       <= '0;
      op_v        <= '0;
      op_tag      <= '0;
      op_data     <= '0;
      ent_pay     <= '0;
      upper_evals <= '0;
      full_hits   <= '0;
    end else begin
      upper_evals <= up_sum;
      full_hits   <= hit_sum;
      for (int e = 0; e < N_ENT; e++) begin
        for (int s = 0; s < 2; s++) begin
          if (wake[e][s]) begin
            op_v[e][s]    <= 1'b1;
            op_data[e][s] <= wake_data[e][s];
          end
        end
        for (int p = 0; p < P; p++)
          if (iss_valid[p] && iss_slot[p] == IDX_W'(e)) ent_v[e] <= 1'b0;
        for (int j = 0; j < P; j++) begin
          if (disp_ready && disp_valid[j] && disp_slot[j] == IDX_W'(e)) begin
            ent_v[e]   <= 1'b1;
            ent_pay[e] <= disp_payload[j];
            op_v[e]    <= cap_v[j];
            op_tag[e]  <= disp_src_tag[j];
            op_data[e] <= cap_d[j];
          end
        end
      end
    end
  end
endmodule

// File: rtl/iq_wakeup_queue_chk.sv
module iq_wakeup_queue_chk #(
  parameter int N_ENT = 64,
  parameter int P     = 4,
  parameter int CNT_W = 10,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    disp_ready,
  input logic [P-1:0]            bus_valid,
  input logic [P-1:0]            iss_valid,
  input logic [CNT_W-1:0]        upper_evals,
  input logic [CNT_W-1:0]        full_hits,
  input logic [N_ENT-1:0]        ent_v,
  input logic [N_ENT-1:0][1:0]   op_v,
  input logic [P-1:0][IDX_W-1:0] iss_slot
);
  AST_FULL_WITHIN_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    full_hits <= upper_evals); // R7

  AST_ISSUE_BOTH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid[0] |-> (ent_v[iss_slot[0]] && op_v[iss_slot[0]] == 2'b11)); // R4

  AST_ISSUE_PACKED: assert property (@(posedge clk) disable iff (!rst_n)
    ((P'(iss_valid + 1'b1)) & iss_valid) == '0); // R9

  AST_ISSUED_FREED: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid[0] |=> !ent_v[$past(iss_slot[0])]); // R9

  AST_STALL_NO_GROWTH: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_ready |=> $countones(ent_v) <= $past($countones(ent_v))); // R10

  AST_IDLE_BUS_NO_EVAL: assert property (@(posedge clk) disable iff (!rst_n)
    !(|bus_valid) |=> (upper_evals == '0 && full_hits == '0)); // R8
endmodule

bind iq_wakeup_queue iq_wakeup_queue_chk #(
  .N_ENT(N_ENT), .P(P), .CNT_W(CNT_W)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .disp_ready (disp_ready),
  .bus_valid  (bus_valid),
  .iss_valid  (iss_valid),
  .upper_evals(upper_evals),
  .full_hits  (full_hits),
  .ent_v      (ent_v),
  .op_v       (op_v),
  .iss_slot   (iss_slot)
);

// File: tb/iq_wakeup_queue_tb.sv
module iq_wakeup_queue_tb_top;
  localparam int N_ENT  = 64;
  localparam int P      = 4;
  localparam int DATA_W = 16;
  localparam int PAY_W  = 8;
  localparam int CNT_W  = $clog2(N_ENT * 2 * P + 1);

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic                          rst_n;
  logic [P-1:0]                  disp_valid;
  logic [P-1:0][PAY_W-1:0]       disp_payload;
  logic [P-1:0][1:0]             disp_src_rdy;
  logic [P-1:0][1:0][7:0]        disp_src_tag;
  logic [P-1:0][1:0][DATA_W-1:0] disp_src_data;
  logic                          disp_ready;
  logic [P-1:0]                  bus_valid;
  logic [P-1:0][7:0]             bus_tag;
  logic [P-1:0][DATA_W-1:0]      bus_data;
  logic [P-1:0]                  iss_valid;
  logic [P-1:0][PAY_W-1:0]       iss_payload;
  logic [P-1:0][1:0][DATA_W-1:0] iss_data;
  logic [CNT_W-1:0]              upper_evals;
  logic [CNT_W-1:0]              full_hits;

  iq_wakeup_queue dut_i (.*);

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    disp_valid = '0; disp_payload = '0; disp_src_rdy = '0;
    disp_src_tag = '0; disp_src_data = '0;
    bus_valid = '0; bus_tag = '0; bus_data = '0;
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic put(int j, logic [7:0] pay, bit r0, logic [7:0] t0, logic [15:0] d0,
                     bit r1, logic [7:0] t1, logic [15:0] d1);
    disp_valid[j]       = 1'b1;
    disp_payload[j]     = pay;
    disp_src_rdy[j]     = {r1, r0};
    disp_src_tag[j][0]  = t0;
    disp_src_tag[j][1]  = t1;
    disp_src_data[j][0] = d0;
    disp_src_data[j][1] = d1;
  endtask

  task automatic bcast(int b, logic [7:0] t, logic [15:0] d);
    bus_valid[b] = 1'b1;
    bus_tag[b]   = t;
    bus_data[b]  = d;
  endtask

  task automatic t_reset();
    chk("R1", "iss_valid", 32'(iss_valid), 0);
    chk("R1", "disp_ready", 32'(disp_ready), 1);
    chk("R1", "upper_evals", 32'(upper_evals), 0);
    chk("R1", "full_hits", 32'(full_hits), 0);
  endtask

  task automatic t_ready_dispatch();
    idle();
    put(0, 8'h11, 1, 8'h00, 16'h0101, 1, 8'h00, 16'h0102);
    put(1, 8'h12, 1, 8'h00, 16'h0201, 1, 8'h00, 16'h0202);
    put(2, 8'h13, 1, 8'h00, 16'h0301, 1, 8'h00, 16'h0302);
    #1 chk("R2", "disp_ready", 32'(disp_ready), 1);
    tick(); idle();
    chk("R2", "iss_valid", 32'(iss_valid), 32'h7);
    chk("R2", "pay0", 32'(iss_payload[0]), 32'h11);
    chk("R2", "pay2", 32'(iss_payload[2]), 32'h13);
    chk("R2", "data1.1", 32'(iss_data[1][1]), 32'h0202);
    tick();
    chk("R9", "freed after issue", 32'(iss_valid), 0);
  endtask

  task automatic t_wakeup_two_ops();
    idle();
    put(0, 8'h20, 0, 8'h35, 16'h0, 0, 8'h47, 16'h0);
    tick(); idle();
    chk("R4", "waiting iss_valid", 32'(iss_valid), 0);
    bcast(0, 8'h35, 16'hAAAA);
    tick(); idle();
    chk("R7", "upper one match", 32'(upper_evals), 1);
    chk("R7", "full one match", 32'(full_hits), 1);
    chk("R4", "half woken", 32'(iss_valid), 0);
    bcast(2, 8'h47, 16'h5555);
    bcast(0, 8'h35, 16'hBBBB);
    tick(); idle();
    chk("R8", "filled slot not compared upper", 32'(upper_evals), 1);
    chk("R8", "filled slot not compared full", 32'(full_hits), 1);
    chk("R3", "iss_valid", 32'(iss_valid), 1);
    chk("R3", "payload", 32'(iss_payload[0]), 32'h20);
    chk("R8", "data0 kept", 32'(iss_data[0][0]), 32'hAAAA);
    chk("R3", "data1", 32'(iss_data[0][1]), 32'h5555);
    tick();
  endtask

  task automatic t_staged_gating();
    idle();
    put(0, 8'h30, 0, 8'h15, 16'h0, 1, 8'h00, 16'h0ABC);
    tick(); idle();
    bcast(1, 8'h25, 16'h1);
    tick(); idle();
    chk("R7", "low nibble only upper", 32'(upper_evals), 1);
    chk("R7", "low nibble only full", 32'(full_hits), 0);
    chk("R7", "no wake", 32'(iss_valid), 0);
    bcast(1, 8'h11, 16'h2);
    tick(); idle();
    chk("R7", "bits1:0 only upper", 32'(upper_evals), 0);
    chk("R7", "bits1:0 only full", 32'(full_hits), 0);
    bcast(3, 8'h15, 16'hC0DE);
    tick(); idle();
    chk("R3", "woken", 32'(iss_valid), 1);
    chk("R3", "data0", 32'(iss_data[0][0]), 32'hC0DE);
    tick();
  endtask

  task automatic t_bus_priority();
    idle();
    put(0, 8'h40, 1, 8'h00, 16'h1234, 0, 8'h60, 16'h0);
    tick(); idle();
    bcast(0, 8'h61, 16'h9999);
    bcast(1, 8'h60, 16'h1111);
    bcast(3, 8'h60, 16'h3333);
    tick(); idle();
    chk("R7", "two full", 32'(full_hits), 2);
    chk("R7", "two upper", 32'(upper_evals), 2);
    chk("R5", "lowest bus value", 32'(iss_data[0][1]), 32'h1111);
    chk("R5", "other op", 32'(iss_data[0][0]), 32'h1234);
    tick();
  endtask

  task automatic t_bypass();
    idle();
    put(0, 8'h50, 0, 8'h70, 16'h0, 1, 8'h00, 16'h2222);
    bcast(2, 8'h70, 16'h7777);
    tick(); idle();
    chk("R6", "iss_valid", 32'(iss_valid), 1);
    chk("R6", "data0", 32'(iss_data[0][0]), 32'h7777);
    chk("R6", "not counted", 32'(upper_evals), 0);
    tick();
  endtask

  task automatic t_multi_issue();
    idle();
    for (int j = 0; j < 4; j++) put(j, 8'(60 + j), 0, 8'h80, 16'h0, 1, 8'h00, 16'(j));
    tick(); idle();
    put(0, 8'd64, 0, 8'h90, 16'h0, 1, 8'h00, 16'h0);
    put(1, 8'd65, 0, 8'h90, 16'h0, 1, 8'h00, 16'h0);
    tick(); idle();
    chk("R4", "all waiting", 32'(iss_valid), 0);
    bcast(0, 8'h80, 16'h0800);
    bcast(1, 8'h90, 16'h0900);
    tick(); idle();
    chk("R7", "shared nibble upper", 32'(upper_evals), 12);
    chk("R7", "six full", 32'(full_hits), 6);
    chk("R9", "four issued", 32'(iss_valid), 32'hF);
    for (int p = 0; p < 4; p++) chk("R2", "order", 32'(iss_payload[p]), 32'(60 + p));
    chk("R9", "data1 port3", 32'(iss_data[3][1]), 3);
    tick();
    chk("R9", "remaining two", 32'(iss_valid), 32'h3);
    chk("R9", "pay port1", 32'(iss_payload[1]), 65);
    chk("R3", "data0 second group", 32'(iss_data[0][0]), 32'h0900);
    tick();
    chk("R9", "drained", 32'(iss_valid), 0);
  endtask

  task automatic t_stall();
    int seen;
    int wrong;
    seen = 0; wrong = 0;
    for (int c = 0; c < 15; c++) begin
      idle();
      for (int j = 0; j < 4; j++) put(j, 8'(c * 4 + j), 0, 8'hF0, 16'h0, 1, 8'h00, 16'h0);
      #1 chk("R2", "fill accepted", 32'(disp_ready), 1);
      tick();
    end
    idle();
    put(0, 8'd60, 0, 8'hF0, 16'h0, 1, 8'h00, 16'h0);
    put(1, 8'd61, 0, 8'hF0, 16'h0, 1, 8'h00, 16'h0);
    tick(); idle();
    for (int j = 0; j < 3; j++) put(j, 8'hEE, 0, 8'hF0, 16'h0, 1, 8'h00, 16'h0);
    #1 chk("R10", "three into two", 32'(disp_ready), 0);
    tick(); idle();
    put(0, 8'd62, 0, 8'hF0, 16'h0, 1, 8'h00, 16'h0);
    put(1, 8'd63, 0, 8'hF0, 16'h0, 1, 8'h00, 16'h0);
    #1 chk("R10", "two into two", 32'(disp_ready), 1);
    tick(); idle();
    put(0, 8'hEE, 0, 8'hF0, 16'h0, 1, 8'h00, 16'h0);
    #1 chk("R10", "full", 32'(disp_ready), 0);
    tick(); idle();
    chk("R4", "full queue waiting", 32'(iss_valid), 0);
    bcast(0, 8'hF0, 16'h0F0F);
    tick(); idle();
    chk("R7", "wake all upper", 32'(upper_evals), 64);
    chk("R7", "wake all full", 32'(full_hits), 64);
    for (int k = 0; k < 16; k++) begin
      for (int p = 0; p < 4; p++) begin
        if (iss_valid[p]) begin
          seen++;
          if (iss_payload[p] !== 8'(k * 4 + p)) wrong++;
        end
      end
      tick();
    end
    chk("R10", "entries issued", 32'(seen), 64);
    chk("R10", "rejected never written", 32'(wrong), 0);
    chk("R9", "empty after drain", 32'(iss_valid), 0);
    for (int j = 0; j < 4; j++) put(j, 8'h01, 1, 8'h00, 16'h0, 1, 8'h00, 16'h0);
    #1 chk("R9", "capacity returned", 32'(disp_ready), 1);
    tick(); idle();
    tick();
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    rst_n = 1'b0;
    idle();
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    #1;
    t_reset();
    t_ready_dispatch();
    t_wakeup_two_ops();
    t_staged_gating();
    t_bus_priority();
    t_bypass();
    t_multi_issue();
    t_stall();
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog (all R): actual timeout expected completion");
      finish_run();
    end
  end
endmodule